// File: doc/BRIEF.md
# Systolic Run Sequencer and Serializer

This block drives one complete multiply pass of a small output-stationary systolic array. The host gives it a single-cycle start pulse and nothing else. The block then produces, cycle by cycle, the strobes the array and its operand feeder need: a one-cycle accumulator clear, an enable window, and a step code. The step code tells the feeder whether to present the first operand step, the second operand step or zero padding.

When the enable window closes, the array has drained and its accumulators hold their final values. The block then places the accumulators on a single result bus, one per cycle, with a valid flag. After the last result it returns to idle, ready for the next start pulse. Operand storage and the multiply-accumulate cells sit outside this block.

Top module: `systolic_run_seq`

## Requirements
- R1: While reset is held and afterwards until a start pulse is seen, arrClear, arrEn and validOut are 0, feedSel is 0 and dataOut is 0.
- R2: In the cycle after the edge that samples start high in idle, arrClear is 1 for exactly one cycle, with arrEn and validOut low and feedSel 0.
- R3: The two cycles after the clear cycle are operand cycles. arrEn is 1 in both. feedSel is 1 in the first, which selects the first operand step, and 2 in the second, which selects the second operand step.
- R4: The two cycles after the operand cycles are drain cycles. arrEn stays 1 and feedSel is 0, which selects zero padding, so the last cell finishes accumulating.
- R5: The four cycles after the drain cycles are result cycles. validOut is 1 in those four cycles only, and arrEn is 0 in them. At most one of arrClear, arrEn and validOut is high in any cycle.
- R6: In the four result cycles, dataOut carries accFlat[7:0] (row 0, column 0), then accFlat[15:8] (row 0, column 1), then accFlat[23:16] (row 1, column 0), then accFlat[31:24] (row 1, column 1).
- R7: dataOut is 0 in every cycle where validOut is 0.
- R8: A start pulse seen while a run is in progress has no effect. The timing of the running pass is unchanged, and no second pass follows.
- R9: After the fourth result cycle the block is idle. A start pulse sampled in the first idle cycle launches a new run with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run launch pulse |
| accFlat | input | 32 | Array accumulators. Cell (r,c) is at bits [(r*2+c)*8 +: 8] |
| arrClear | output | 1 | Clears the array accumulators |
| arrEn | output | 1 | Accumulate enable for the array |
| feedSel | output | 2 | Feeder step code: 0 selects zeros, k selects operand step k |
| validOut | output | 1 | dataOut holds a result |
| dataOut | output | 8 | Serialized result word |

## Verification
Each pass is checked cycle by cycle against a timeline computed from the run position. The checks cover the clear cycle, the step codes, the enable window, the valid window and the result words. Random accumulator contents show that each result cycle selects its own slot and that no two slots are swapped. Passes are run with and without stray start pulses injected inside the run. These show that a busy block ignores start, while a start in the first idle cycle after a run is honoured at once. The passes run back to back after reset, with no gap cycle between one run's end and the next start.

// File: rtl/systolic_run_pkg.sv
package systolic_run_pkg;

  // Phase of one multiply pass
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CLEAR = 3'd1,
    PH_FEED  = 3'd2,
    PH_DRAIN = 3'd3,
    PH_READ  = 3'd4
  } runPhase_t;

  // Strobes handed from the control path to the datapath
  typedef struct packed {
    logic clear;
    logic feed;
    logic drain;
    logic read;
  } runStrobe_t;

endpackage

// File: rtl/systolic_run_ctrl.sv
module systolic_run_ctrl
  import systolic_run_pkg::*;
#(
  parameter int STEPS     = 2,
  parameter int DRAIN_CYC = 2,
  parameter int NRES      = 4,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output runStrobe_t       strobe,
  output logic [CNT_W-1:0] phaseCnt
);

  localparam logic [CNT_W-1:0] FEED_LAST  = CNT_W'(STEPS - 1);
  localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(DRAIN_CYC - 1);
  localparam logic [CNT_W-1:0] READ_LAST  = CNT_W'(NRES - 1);

  runPhase_t        phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    phaseNext = phase;
    cntNext   = cnt;
    unique case (phase)
      PH_IDLE: begin
        if (start) phaseNext = PH_CLEAR;
        cntNext = '0;
      end
      PH_CLEAR: begin
        phaseNext = PH_FEED;
        cntNext   = '0;
      end
      PH_FEED: begin
        if (cnt == FEED_LAST) begin
          phaseNext = PH_DRAIN;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      PH_DRAIN: begin
        if (cnt == DRAIN_LAST) begin
          phaseNext = PH_READ;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      PH_READ: begin
        if (cnt == READ_LAST) begin
          phaseNext = PH_IDLE;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      default: begin
        phaseNext = PH_IDLE;
        cntNext   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phaseNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.clear = (phase == PH_CLEAR);
    strobe.feed  = (phase == PH_FEED);
    strobe.drain = (phase == PH_DRAIN);
    strobe.read  = (phase == PH_READ);
  end

  assign phaseCnt = cnt;

endmodule

// File: rtl/systolic_run_dpath.sv
module systolic_run_dpath
  import systolic_run_pkg::*;
#(
  parameter int ACC_W  = 8,
  parameter int NRES   = 4,
  parameter int CNT_W  = 3,
  parameter int STEP_W = 2
) (
  input  runStrobe_t          strobe,
  input  logic [CNT_W-1:0]    phaseCnt,
  input  logic [NRES*ACC_W-1:0] accFlat,
  output logic                arrClear,
  output logic                arrEn,
  output logic [STEP_W-1:0]   feedSel,
  output logic                validOut,
  output logic [ACC_W-1:0]    dataOut
);

  logic [ACC_W-1:0] accSlot [NRES];

  for (genvar i = 0; i < NRES; i++) begin : g_slot
    assign accSlot[i] = accFlat[i*ACC_W +: ACC_W];
  end

  assign arrClear = strobe.clear;
  assign arrEn    = strobe.feed | strobe.drain;
  assign validOut = strobe.read;

  // Step code: operand step k is k+1 while feeding, zero padding otherwise
  always_comb begin
    if (strobe.feed) feedSel = STEP_W'(phaseCnt) + 1'b1;
    else             feedSel = '0;
  end

  // Result selection, forced to zero outside the readout window
  always_comb begin
    dataOut = '0;
    for (int i = 0; i < NRES; i++) begin
      if (strobe.read && (phaseCnt == CNT_W'(i))) dataOut = accSlot[i];
    end
  end

endmodule

// File: rtl/systolic_run_seq.sv
module systolic_run_seq
  import systolic_run_pkg::*;
#(
  parameter int ROWS      = 2,
  parameter int COLS      = 2,
  parameter int ACC_W     = 8,
  parameter int STEPS     = 2,
  parameter int DRAIN_CYC = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [ROWS*COLS*ACC_W-1:0]  accFlat,
  output logic                        arrClear,
  output logic                        arrEn,
  output logic [$clog2(STEPS+1)-1:0]  feedSel,
  output logic                        validOut,
  output logic [ACC_W-1:0]            dataOut
);

  localparam int NRES    = ROWS * COLS;
  localparam int MAX_CNT = (NRES > STEPS) ? ((NRES > DRAIN_CYC) ? NRES : DRAIN_CYC)
                                          : ((STEPS > DRAIN_CYC) ? STEPS : DRAIN_CYC);
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int STEP_W  = $clog2(STEPS + 1);

  runStrobe_t       strobe;
  logic [CNT_W-1:0] phaseCnt;

  systolic_run_ctrl #(
    .STEPS(STEPS), .DRAIN_CYC(DRAIN_CYC), .NRES(NRES), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobe(strobe), .phaseCnt(phaseCnt)
  );

  systolic_run_dpath #(
    .ACC_W(ACC_W), .NRES(NRES), .CNT_W(CNT_W), .STEP_W(STEP_W)
  ) u_dpath (
    .strobe(strobe), .phaseCnt(phaseCnt), .accFlat(accFlat),
    .arrClear(arrClear), .arrEn(arrEn), .feedSel(feedSel),
    .validOut(validOut), .dataOut(dataOut)
  );

endmodule

// File: rtl/systolic_run_seq_chk.sv
module systolic_run_seq_chk #(
  parameter int NRES   = 4,
  parameter int ACC_W  = 8,
  parameter int STEP_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              arrClear,
  input logic              arrEn,
  input logic [STEP_W-1:0] feedSel,
  input logic              validOut,
  input logic [ACC_W-1:0]  dataOut
);

  logic [7:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN)         runLen <= '0;
    else if (validOut) runLen <= runLen + 1'b1;
    else               runLen <= '0;
  end

  // R2
  clear_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrClear |=> (!arrClear && arrEn && feedSel == STEP_W'(1)));

  // R3
  step_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arrEn && feedSel == STEP_W'(1)) |=> (arrEn && feedSel == STEP_W'(2)));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({arrClear, arrEn, validOut}));

  // R5
  valid_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (runLen < 8'(NRES)));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> (dataOut == '0));

  // R4
  drain_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arrEn && feedSel == STEP_W'(2)) |=> (arrEn && feedSel == '0));

endmodule

bind systolic_run_seq systolic_run_seq_chk #(
  .NRES(ROWS*COLS), .ACC_W(ACC_W), .STEP_W($clog2(STEPS+1))
) u_chk (
  .clk(clk), .rstN(rstN), .arrClear(arrClear), .arrEn(arrEn),
  .feedSel(feedSel), .validOut(validOut), .dataOut(dataOut)
);

// File: tb/systolic_run_seq_tb.sv
`timescale 1ns/1ps
module systolic_run_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] accFlat = '0;
  logic        arrClear, arrEn, validOut;
  logic [1:0]  feedSel;
  logic [7:0]  dataOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  systolic_run_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .accFlat(accFlat),
    .arrClear(arrClear), .arrEn(arrEn), .feedSel(feedSel),
    .validOut(validOut), .dataOut(dataOut)
  );

  // Expected {clear, en, sel[1:0], valid, data[7:0]} at run position c
  function automatic logic [12:0] expectAt(int c, logic [31:0] acc);
    logic [12:0] e;
    e = '0;
    if (c == 0)               e[12] = 1'b1;
    else if (c == 1)          e[11:9] = 3'b1_01;
    else if (c == 2)          e[11:9] = 3'b1_10;
    else if (c == 3 || c == 4) e[11:9] = 3'b1_00;
    else if (c >= 5 && c <= 8) begin
      e[8]   = 1'b1;
      e[7:0] = acc[(c-5)*8 +: 8];
    end
    return e;
  endfunction

  function automatic string reqOf(int c);
    if (c < 0)       return "R1";
    else if (c == 0) return "R2";
    else if (c <= 2) return "R3";
    else if (c <= 4) return "R4";
    else if (c <= 8) return "R5/R6";
    else             return "R7/R9";
  endfunction

  task automatic checkNow(int c, logic [12:0] exp, string tag);
    logic [12:0] act;
    act = {arrClear, arrEn, feedSel, validOut, dataOut};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pos %0d actual %h expected %h", tag, c, act, exp);
    end
  endtask

  // One pass; noisy=1 injects stray start pulses mid-run (R8)
  task automatic runPass(logic [31:0] acc, bit noisy);
    accFlat = acc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    checkNow(0, expectAt(0, acc), noisy ? "R8 R2" : "R2");
    for (int c = 1; c <= 9; c++) begin
      @(negedge clk);
      checkNow(c, expectAt(c, acc), noisy ? {"R8 ", reqOf(c)} : reqOf(c));
      if (noisy && c <= 8) start = $urandom_range(0, 1) == 1;
      else start = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd7331));
    repeat (4) @(negedge clk);
    checkNow(-1, 13'd0, "R1");
    rstN = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    checkNow(-1, 13'd0, "R1");
    // directed: distinct byte slots, then extremes (R6)
    runPass(32'h44_33_22_11, 1'b0);
    runPass(32'h80_7F_FF_00, 1'b0);
    // directed: start held high throughout the run (R8), then back to back (R9)
    accFlat = 32'hA5_5A_C3_3C;
    start = 1'b1;
    @(negedge clk);
    checkNow(0, expectAt(0, accFlat), "R8 R2");
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      checkNow(c, expectAt(c, accFlat), {"R8 ", reqOf(c)});
    end
    start = 1'b0;
    @(negedge clk);
    checkNow(9, 13'd0, "R8 R9");
    // random passes, alternating stray starts
    for (int n = 0; n < 30; n++) runPass($urandom(), n[0]);
    // idle stays quiet with moving accumulators (R7)
    for (int k = 0; k < 5; k++) begin
      accFlat = $urandom();
      @(negedge clk);
      checkNow(10, 13'd0, "R7");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000 && !done) begin
        checks++;
        errors++;
        $display("FAIL watchdog expired actual %0d expected below 50000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

endmodule